// File: doc/BRIEF.md
# Time-Slotted Shared Image Bus Controller

This controller arbitrates one shared image bus by time division. The bus runs at sixteen times the pixel rate, so each pixel period holds sixteen bus cycles, called slots. A free-running slot counter names the current slot. An allocation table holds one entry per slot. Each entry gives an optional transmitting card and a mask of cards that capture the word. From the active entry the controller raises one transmit enable, selects that card's word onto the bus and raises the receive strobes of every listening card.

The host programs a shadow copy of the table at any time. A frame-start pulse arms a swap. The shadow copy becomes the active table at the first slot-0 cycle after the pulse, so ownership can change from frame to frame without tearing a pixel period. Any number of cards can be attached. The slot count limits only how many cards transmit in one pixel period. One card may transmit in several slots.

The control path has three states. `ST_IDLE` is entered at reset and lasts until a table has been activated. `ST_PEND` is entered when a swap is armed. `ST_RUN` means a table is active and no swap is pending. The transitions are:
- IDLE→PEND and RUN→PEND on a frame-start pulse when the slot is not the last.
- IDLE→RUN and RUN→RUN with a swap on a frame-start pulse in the last slot.
- PEND→RUN with a swap in the last slot.
- Any other cycle holds the current state.

Top module: `tdm_bus_ctrl`

## Requirements
- R1: `slot_idx` is 0 in the first cycle after reset. It increases by one every cycle and wraps from NUM_SLOTS-1 to 0.
- R2: `pixel_phase` is high exactly in the cycles where `slot_idx` is 0.
- R3: From reset until the first table activation, `tx_en` and `rx_strobe` are all zero and `bus_data` is zero, whatever the card data is.
- R4: A table write (`cfg_we`) changes only the shadow copy. Outputs do not change until an activation.
- R5: A `frame_start` pulse activates the shadow table from the first cycle with `slot_idx` 0 that comes strictly after the pulse cycle. A pulse in the last slot activates it in the very next cycle. Further pulses while a swap is pending do not delay it.
- R6: In a slot whose active entry is valid with card id T, only `tx_en[T]` is high. `bus_data` equals bits `[T*DATA_W +: DATA_W]` of `card_tx_data`, and `rx_strobe` equals the entry's receive mask.
- R7: In a slot whose active entry is not valid, `bus_data` is zero and all `tx_en` and `rx_strobe` bits are zero.
- R8: A card assigned in several slots has its `tx_en` high in those slots only.
- R9: A write in the same cycle as the activation edge lands in the shadow copy only. The active table receives the shadow contents from before that write.
- R10: Without a new `frame_start`, the active table repeats unchanged in every pixel period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that arms a table swap |
| cfg_we | input | 1 | Shadow table write enable |
| cfg_slot | input | SLOT_W | Slot written |
| cfg_tx_valid | input | 1 | Slot has a transmitter |
| cfg_tx_id | input | CARD_W | Transmitting card id |
| cfg_rx_mask | input | NUM_CARDS | Cards that capture the slot |
| card_tx_data | input | NUM_CARDS*DATA_W | Word offered by each card, card c at `[c*DATA_W +: DATA_W]` |
| slot_idx | output | SLOT_W | Current slot |
| pixel_phase | output | 1 | High in slot 0 |
| tx_en | output | NUM_CARDS | Per-card transmit enable |
| rx_strobe | output | NUM_CARDS | Per-card receive strobe |
| bus_data | output | DATA_W | Word on the shared bus |

## Verification
The bench aims at the activation edge in several ways. It pulses in the last slot, pulses in slot 0 and repeats pulses while a swap is pending. A design that swaps one slot early or late, or at the pulse itself, tears a pixel period, and the per-cycle model comparison catches it. A write placed on the swap edge exposes a design that copies the post-write shadow. Empty slots are driven with busy card data to expose a bus that leaks a stale word or strobes receivers. A card programmed in three slots catches enables that spill over into neighbouring slots.

// File: rtl/tdm_bus_pkg.sv
package tdm_bus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RUN  = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_last,
    output logic              slot_first
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
        end else if (slot == LAST) begin
            slot <= '0;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    assign slot_last  = (slot == LAST);
    assign slot_first = (slot == '0);

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_CARDS = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CARD_W = $clog2(NUM_CARDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SLOT_W-1:0]    wr_slot,
    input  logic                 wr_valid,
    input  logic [CARD_W-1:0]    wr_tx,
    input  logic [NUM_CARDS-1:0] wr_rx,
    input  logic                 swap,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic                 rd_valid,
    output logic [CARD_W-1:0]    rd_tx,
    output logic [NUM_CARDS-1:0] rd_rx
);

    logic                 sh_valid [NUM_SLOTS];
    logic [CARD_W-1:0]    sh_tx    [NUM_SLOTS];
    logic [NUM_CARDS-1:0] sh_rx    [NUM_SLOTS];
    logic                 ac_valid [NUM_SLOTS];
    logic [CARD_W-1:0]    ac_tx    [NUM_SLOTS];
    logic [NUM_CARDS-1:0] ac_rx    [NUM_SLOTS];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_valid[s] <= 1'b0;
                sh_tx[s]    <= '0;
                sh_rx[s]    <= '0;
            end else if (wr_en && wr_slot == SLOT_W'(s)) begin
                sh_valid[s] <= wr_valid;
                sh_tx[s]    <= wr_tx;
                sh_rx[s]    <= wr_rx;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ac_valid[s] <= 1'b0;
                ac_tx[s]    <= '0;
                ac_rx[s]    <= '0;
            end else if (swap) begin
                ac_valid[s] <= sh_valid[s];
                ac_tx[s]    <= sh_tx[s];
                ac_rx[s]    <= sh_rx[s];
            end
        end
    end

    assign rd_valid = ac_valid[rd_slot];
    assign rd_tx    = ac_tx[rd_slot];
    assign rd_rx    = ac_rx[rd_slot];

endmodule

// File: rtl/tdm_slot_decoder.sv
module tdm_slot_decoder #(
    parameter int NUM_CARDS = 8,
    parameter int DATA_W = 8,
    localparam int CARD_W = $clog2(NUM_CARDS)
) (
    input  logic                        ent_valid,
    input  logic [CARD_W-1:0]           ent_tx,
    input  logic [NUM_CARDS-1:0]        ent_rx,
    input  logic [NUM_CARDS*DATA_W-1:0] card_data,
    output logic [NUM_CARDS-1:0]        tx_en,
    output logic [NUM_CARDS-1:0]        rx_strobe,
    output logic [DATA_W-1:0]           bus_data
);

    logic [DATA_W-1:0] gated [NUM_CARDS];

    for (genvar c = 0; c < NUM_CARDS; c++) begin : g_card
        assign tx_en[c] = ent_valid && (ent_tx == CARD_W'(c));
        assign gated[c] = tx_en[c] ? card_data[c*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        bus_data = '0;
        for (int c = 0; c < NUM_CARDS; c++) begin
            bus_data = bus_data | gated[c];
        end
    end

    assign rx_strobe = ent_valid ? ent_rx : '0;

endmodule

// File: rtl/tdm_bus_ctrl.sv
module tdm_bus_ctrl
    import tdm_bus_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_CARDS = 8,
    parameter int DATA_W = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CARD_W = $clog2(NUM_CARDS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start,
    input  logic                        cfg_we,
    input  logic [SLOT_W-1:0]           cfg_slot,
    input  logic                        cfg_tx_valid,
    input  logic [CARD_W-1:0]           cfg_tx_id,
    input  logic [NUM_CARDS-1:0]        cfg_rx_mask,
    input  logic [NUM_CARDS*DATA_W-1:0] card_tx_data,
    output logic [SLOT_W-1:0]           slot_idx,
    output logic                        pixel_phase,
    output logic [NUM_CARDS-1:0]        tx_en,
    output logic [NUM_CARDS-1:0]        rx_strobe,
    output logic [DATA_W-1:0]           bus_data
);

    ctrl_state_t state, state_nx;
    logic        slot_last;
    logic        swap;
    logic        ent_valid;
    logic [CARD_W-1:0]    ent_tx;
    logic [NUM_CARDS-1:0] ent_rx;

    tdm_slot_counter #(.NUM_SLOTS(NUM_SLOTS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot       (slot_idx),
        .slot_last  (slot_last),
        .slot_first (pixel_phase)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        swap     = 1'b0;
        unique case (state)
            ST_IDLE, ST_RUN: begin
                if (frame_start) begin
                    swap     = slot_last;
                    state_nx = slot_last ? ST_RUN : ST_PEND;
                end
            end
            ST_PEND: begin
                if (slot_last) begin
                    swap     = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    tdm_slot_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_CARDS(NUM_CARDS)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_slot  (cfg_slot),
        .wr_valid (cfg_tx_valid),
        .wr_tx    (cfg_tx_id),
        .wr_rx    (cfg_rx_mask),
        .swap     (swap),
        .rd_slot  (slot_idx),
        .rd_valid (ent_valid),
        .rd_tx    (ent_tx),
        .rd_rx    (ent_rx)
    );

    tdm_slot_decoder #(.NUM_CARDS(NUM_CARDS), .DATA_W(DATA_W)) u_dec (
        .ent_valid (ent_valid),
        .ent_tx    (ent_tx),
        .ent_rx    (ent_rx),
        .card_data (card_tx_data),
        .tx_en     (tx_en),
        .rx_strobe (rx_strobe),
        .bus_data  (bus_data)
    );

endmodule

// File: rtl/tdm_bus_ctrl_chk.sv
module tdm_bus_ctrl_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int NUM_CARDS = 8,
    parameter int DATA_W = 8,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int CARD_W = $clog2(NUM_CARDS)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frame_start,
    input logic                        cfg_we,
    input logic [SLOT_W-1:0]           cfg_slot,
    input logic                        cfg_tx_valid,
    input logic [CARD_W-1:0]           cfg_tx_id,
    input logic [NUM_CARDS-1:0]        cfg_rx_mask,
    input logic [NUM_CARDS*DATA_W-1:0] card_tx_data,
    input logic [SLOT_W-1:0]           slot_idx,
    input logic                        pixel_phase,
    input logic [NUM_CARDS-1:0]        tx_en,
    input logic [NUM_CARDS-1:0]        rx_strobe,
    input logic [DATA_W-1:0]           bus_data
);

    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != '0) |-> ($past(slot_idx) == SLOT_W'(slot_idx - 1'b1)));

    p_phase_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_phase |=> !pixel_phase);

    p_single_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_en));

    p_quiet_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en == '0) |-> (rx_strobe == '0 && bus_data == '0));

    for (genvar c = 0; c < NUM_CARDS; c++) begin : g_src
        p_bus_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
            tx_en[c] |-> (bus_data == card_tx_data[c*DATA_W +: DATA_W]));
    end

endmodule

bind tdm_bus_ctrl tdm_bus_ctrl_chk #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_CARDS(NUM_CARDS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tdm_bus_ctrl_test.sv
module tdm_bus_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NC = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_start;
    logic          cfg_we;
    logic [3:0]    cfg_slot;
    logic          cfg_tx_valid;
    logic [2:0]    cfg_tx_id;
    logic [NC-1:0] cfg_rx_mask;
    logic [NC*DW-1:0] card_tx_data;
    logic [3:0]    slot_idx;
    logic          pixel_phase;
    logic [NC-1:0] tx_en;
    logic [NC-1:0] rx_strobe;
    logic [DW-1:0] bus_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string ctx  = "reset";

    // bench model
    bit          m_sh_v  [NS];
    bit [2:0]    m_sh_tx [NS];
    bit [NC-1:0] m_sh_rx [NS];
    bit          m_ac_v  [NS];
    bit [2:0]    m_ac_tx [NS];
    bit [NC-1:0] m_ac_rx [NS];
    int          m_slot;
    bit          m_pend;
    bit          m_live;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_we(cfg_we),
        .cfg_slot(cfg_slot), .cfg_tx_valid(cfg_tx_valid), .cfg_tx_id(cfg_tx_id),
        .cfg_rx_mask(cfg_rx_mask), .card_tx_data(card_tx_data),
        .slot_idx(slot_idx), .pixel_phase(pixel_phase), .tx_en(tx_en),
        .rx_strobe(rx_strobe), .bus_data(bus_data)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] slot=%0d actual=%h expected=%h", req, ctx, m_slot, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_tx(int s);
        return m_ac_v[s] ? NC'(1) << m_ac_tx[s] : '0;
    endfunction

    function automatic logic [NC-1:0] exp_rx(int s);
        return m_ac_v[s] ? m_ac_rx[s] : '0;
    endfunction

    function automatic logic [DW-1:0] exp_bus(int s, logic [NC*DW-1:0] d);
        return m_ac_v[s] ? d[m_ac_tx[s]*DW +: DW] : '0;
    endfunction

    // one bus cycle: drive at negedge, check, advance model, wait next negedge
    task automatic step(bit fs, bit we, int ws, bit wv, int wt, logic [NC-1:0] wr);
        string tag;
        frame_start  = fs;
        cfg_we       = we;
        cfg_slot     = 4'(ws);
        cfg_tx_valid = wv;
        cfg_tx_id    = 3'(wt);
        cfg_rx_mask  = wr;
        card_tx_data = {$urandom, $urandom};
        #1;
        tag = !m_live ? "R3" : (m_ac_v[m_slot] ? "R6" : "R7");
        check(slot_idx == 4'(m_slot), "R1", 64'(slot_idx), 64'(m_slot));
        check(pixel_phase == (m_slot == 0), "R2", 64'(pixel_phase), 64'(m_slot == 0));
        check(tx_en == exp_tx(m_slot), tag, 64'(tx_en), 64'(exp_tx(m_slot)));
        check(rx_strobe == exp_rx(m_slot), tag, 64'(rx_strobe), 64'(exp_rx(m_slot)));
        check(bus_data == exp_bus(m_slot, card_tx_data), tag, 64'(bus_data),
              64'(exp_bus(m_slot, card_tx_data)));
        if ((m_pend || fs) && m_slot == NS-1) begin
            for (int s = 0; s < NS; s++) begin
                m_ac_v[s]  = m_sh_v[s];
                m_ac_tx[s] = m_sh_tx[s];
                m_ac_rx[s] = m_sh_rx[s];
            end
            m_pend = 0;
            m_live = 1;
        end else if (fs) begin
            m_pend = 1;
        end
        if (we) begin
            m_sh_v[ws]  = wv;
            m_sh_tx[ws] = 3'(wt);
            m_sh_rx[ws] = wr;
        end
        m_slot = (m_slot + 1) % NS;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0);
    endtask

    task automatic run_to_slot(int s);
        while (m_slot != s) step(0, 0, 0, 0, 0, '0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) begin
            m_sh_v[s] = 0; m_sh_tx[s] = 0; m_sh_rx[s] = 0;
            m_ac_v[s] = 0; m_ac_tx[s] = 0; m_ac_rx[s] = 0;
        end
        m_slot = 0; m_pend = 0; m_live = 0;
        rst_n = 1'b0; frame_start = 0; cfg_we = 0; cfg_slot = 0;
        cfg_tx_valid = 0; cfg_tx_id = 0; cfg_rx_mask = 0; card_tx_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: quiet bus before any activation
        ctx = "R3 reset";
        idle(20);

        // R4: shadow writes alone leave the outputs untouched
        ctx = "R4 shadow";
        for (int s = 0; s < NS; s++)
            step(0, 1, s, (s != 5), s % NC, NC'($urandom));
        idle(20);

        // R5: pulse mid-period, second pulse while pending
        ctx = "R5 mid";
        run_to_slot(3);
        step(1, 0, 0, 0, 0, '0);
        run_to_slot(9);
        step(1, 0, 0, 0, 0, '0);
        idle(20);

        // R5: pulse in slot 0 waits a full period; pulse in last slot swaps next cycle
        ctx = "R5 edge";
        step(0, 1, 0, 1, 6, 8'hF0);
        run_to_slot(0);
        step(1, 0, 0, 0, 0, '0);
        idle(20);
        step(0, 1, 0, 1, 1, 8'h0F);
        run_to_slot(NS-1);
        step(1, 0, 0, 0, 0, '0);
        idle(3);

        // R8: one card owns three slots, rest empty
        ctx = "R8 multi";
        for (int s = 0; s < NS; s++)
            step(0, 1, s, (s == 1 || s == 7 || s == 12), 2, NC'($urandom));
        step(1, 0, 0, 0, 0, '0);
        idle(40);

        // R9: write on the swap edge stays in shadow
        ctx = "R9 swap-edge";
        run_to_slot(4);
        step(1, 0, 0, 0, 0, '0);
        run_to_slot(NS-1);
        step(0, 1, 0, 1, 7, 8'hAA);
        idle(20);
        run_to_slot(NS-1);
        step(1, 0, 0, 0, 0, '0);
        idle(3);

        // R10: table persists across pixel periods
        ctx = "R10 hold";
        idle(48);

        // random mix
        ctx = "random";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 40) == 0, ($urandom % 4) == 0, int'($urandom % NS),
                 ($urandom % 4) != 0, int'($urandom % NC), NC'($urandom));
        end

        done = 1;
        finish_run();
    end

endmodule